// File: doc/BRIEF.md
# Segment Access Permission Checker

This block sits in front of address translation and judges every memory access against the cached copy of the segment register that the access names. The requester supplies the segment index and that segment's cached selector, base, limit and attribute bits. It also supplies the access offset, its size in bytes, and whether the access is a write or an instruction fetch. One cycle later the block returns either a general-protection fault flag or the linear address, which is the base plus the offset.

Only a contiguous low range of segment indices, set by parameters and 0 through 6 by default, has its selector and attributes inspected. Every other index is a system-table or internal segment. For those the block skips the null-selector and read/write tests and always applies the expand-up limit test. Paging, alignment checks and splitting of page-crossing accesses belong to later stages.

Top module: `seg_access_check`

## Requirements
- R1: A request presented with `req_valid` high on a rising clock edge produces `rsp_valid` high for exactly the following cycle. `rsp_valid` is low in every cycle that does not follow a request, and all outputs are zero after reset.
- R2: When a response carries no fault, `rsp_addr` equals `req_base + req_offset` modulo 2^AW. When `rsp_fault` is high or `rsp_valid` is low, `rsp_addr` is zero.
- R3: For a segment index inside the checked range, 0 to 6 by default, a selector that is entirely zero raises `rsp_fault`.
- R4: For a checked index, a write (`req_write`=1) to a segment whose `req_writable` bit is 0 raises `rsp_fault`.
- R5: For a checked index, a data read (`req_write`=0 and `req_fetch`=0) to a segment whose `req_readable` bit is 0 raises `rsp_fault`. An instruction fetch ignores `req_readable`.
- R6: For an index outside the checked range, the selector value and the `req_readable`, `req_writable` and `req_expdown` bits have no effect. Such a segment is always treated as expand-up with no read/write restriction.
- R7: Under the expand-up test, the access faults when its last byte address, `req_offset + size - 1`, is greater than `req_limit`. The sum is taken with one extra carry bit, so an access that wraps past 2^AW faults. A `req_size` of 0 counts as 1 byte.
- R8: For a checked index with `req_expdown`=1, the access faults when `req_offset` is less than or equal to `req_limit`, and passes otherwise.
- R9: When several fault conditions hold together, the result is one fault flag with a zero address. Back-to-back requests are each judged on their own inputs, with no influence from the request before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_seg | input | SW | Segment register index |
| req_sel | input | SELW | Cached selector of the segment |
| req_base | input | AW | Cached segment base |
| req_limit | input | AW | Cached segment limit |
| req_readable | input | 1 | Segment attribute: data reads allowed |
| req_writable | input | 1 | Segment attribute: writes allowed |
| req_expdown | input | 1 | Segment attribute: expand-down |
| req_offset | input | AW | Access offset within the segment |
| req_size | input | SZW | Access size in bytes (0 treated as 1) |
| req_write | input | 1 | Access is a write |
| req_fetch | input | 1 | Access is an instruction fetch |
| rsp_valid | output | 1 | Result present this cycle |
| rsp_fault | output | 1 | General-protection fault |
| rsp_addr | output | AW | Linear address, zero on fault |

## Verification
A permission fault and a limit violation can occur in the same cycle. Examples are a write to a read-only segment whose last byte also lies past the limit, and a null selector together with an out-of-range offset. The bench issues such requests back to back with clean ones. It expects a single fault flag with a zero address, and it expects the next clean request to return its full sum. A reference model computes these results in the bench, with separate terms and 64-bit arithmetic. A scoreboard queue compares each response to the model in order.

// File: rtl/seg_access_check.sv
module seg_access_check #(
  parameter int AW     = 32,
  parameter int SW     = 4,
  parameter int SELW   = 16,
  parameter int SZW    = 4,
  parameter int CHK_LO = 0,
  parameter int CHK_HI = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [SW-1:0]   req_seg,
  input  logic [SELW-1:0] req_sel,
  input  logic [AW-1:0]   req_base,
  input  logic [AW-1:0]   req_limit,
  input  logic            req_readable,
  input  logic            req_writable,
  input  logic            req_expdown,
  input  logic [AW-1:0]   req_offset,
  input  logic [SZW-1:0]  req_size,
  input  logic            req_write,
  input  logic            req_fetch,
  output logic            rsp_valid,
  output logic            rsp_fault,
  output logic [AW-1:0]   rsp_addr
);

  localparam int EW = AW + 1;

  logic            in_chk;
  logic [SZW-1:0]  eff_size;
  logic [EW-1:0]   last_byte;
  logic            null_f, wr_f, rd_f, up_f, dn_f, lim_f, any_f;

  assign in_chk    = (int'(req_seg) >= CHK_LO) && (int'(req_seg) <= CHK_HI);
  assign eff_size  = (req_size == '0) ? SZW'(1) : req_size;
  assign last_byte = {1'b0, req_offset} + EW'(eff_size) - EW'(1);

  assign null_f = in_chk && (req_sel == '0);
  assign wr_f   = in_chk && req_write && !req_writable;
  assign rd_f   = in_chk && !req_write && !req_fetch && !req_readable;
  assign up_f   = last_byte > {1'b0, req_limit};
  assign dn_f   = req_offset <= req_limit;
  assign lim_f  = (in_chk && req_expdown) ? dn_f : up_f;
  assign any_f  = null_f || wr_f || rd_f || lim_f;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid && any_f;
      rsp_addr  <= (req_valid && !any_f) ? (req_base + req_offset) : '0;
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_addr_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault || !rsp_valid) |-> (rsp_addr == '0));
  p_fault_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_valid);
  p_addr_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid ##1 (rsp_valid && !rsp_fault)) |->
      (rsp_addr == $past(req_base) + $past(req_offset)));
  p_null_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && int'(req_seg) >= CHK_LO && int'(req_seg) <= CHK_HI
     && req_sel == '0) |=> rsp_fault);
  p_ro_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && int'(req_seg) >= CHK_LO && int'(req_seg) <= CHK_HI
     && req_write && !req_writable) |=> rsp_fault);

endmodule

// File: tb/seg_access_check_test.sv
`timescale 1ns/1ps
module seg_access_check_test;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [3:0]    req_seg = '0;
  logic [15:0]   req_sel = '0;
  logic [AW-1:0] req_base = '0;
  logic [AW-1:0] req_limit = '0;
  logic          req_readable = 1'b0;
  logic          req_writable = 1'b0;
  logic          req_expdown = 1'b0;
  logic [AW-1:0] req_offset = '0;
  logic [3:0]    req_size = '0;
  logic          req_write = 1'b0;
  logic          req_fetch = 1'b0;
  logic          rsp_valid, rsp_fault;
  logic [AW-1:0] rsp_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit            q_fault[$];
  logic [AW-1:0] q_addr[$];
  string         q_tag[$];

  always #2.5 clk = ~clk;

  seg_access_check uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_seg(req_seg),
    .req_sel(req_sel), .req_base(req_base), .req_limit(req_limit),
    .req_readable(req_readable), .req_writable(req_writable),
    .req_expdown(req_expdown), .req_offset(req_offset), .req_size(req_size),
    .req_write(req_write), .req_fetch(req_fetch),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_addr(rsp_addr)
  );

  function automatic bit model_fault(int seg, int sel, longint lim, bit rd,
                                     bit wr, bit ed, longint off, int sz,
                                     bit w, bit f);
    bit chk;
    longint n;
    chk = (seg <= 6);
    n = (sz == 0) ? 1 : sz;
    if (chk && sel == 0) return 1;
    if (chk && w && !wr) return 1;
    if (chk && !w && !f && !rd) return 1;
    if (chk && ed) return off <= lim;
    return (off + n - 1) > lim;
  endfunction

  task automatic send(string tag, int seg, int sel, longint base, longint lim,
                      bit rd, bit wr, bit ed, longint off, int sz, bit w, bit f);
    bit flt;
    @(negedge clk);
    req_valid = 1'b1; req_seg = 4'(seg); req_sel = 16'(sel);
    req_base = AW'(base); req_limit = AW'(lim);
    req_readable = rd; req_writable = wr; req_expdown = ed;
    req_offset = AW'(off); req_size = 4'(sz); req_write = w; req_fetch = f;
    flt = model_fault(seg, sel, lim, rd, wr, ed, off, sz, w, f);
    q_fault.push_back(flt);
    q_addr.push_back(flt ? '0 : AW'(base + off));
    q_tag.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  always begin
    @(posedge clk);
    #1;
    if (rst_n && !done) begin
      if (rsp_valid) begin
        checks++;
        if (q_fault.size() == 0) begin
          errors++;
          $display("FAIL R1: unexpected response fault=%0b addr=%h expected none",
                   rsp_fault, rsp_addr);
        end else begin
          bit ef;
          logic [AW-1:0] ea;
          string t;
          ef = q_fault.pop_front();
          ea = q_addr.pop_front();
          t  = q_tag.pop_front();
          if (rsp_fault !== ef || rsp_addr !== ea) begin
            errors++;
            $display("FAIL %s: fault=%0b addr=%h expected fault=%0b addr=%h",
                     t, rsp_fault, rsp_addr, ef, ea);
          end
        end
      end else if (rsp_fault !== 1'b0 || rsp_addr !== '0) begin
        checks++;
        errors++;
        $display("FAIL R2: idle outputs fault=%0b addr=%h expected 0 0",
                 rsp_fault, rsp_addr);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1: watchdog expired, actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_fault !== 1'b0 || rsp_addr !== '0) begin
      errors++;
      $display("FAIL R1: reset outputs %0b %0b %h expected 0 0 0",
               rsp_valid, rsp_fault, rsp_addr);
    end
    rst_n = 1'b1;
    idle(2);

    send("R2",  3, 16'h10, 64'h1000, 64'hFFF, 1, 1, 0, 64'h20, 4, 0, 0);
    send("R7",  3, 16'h10, 64'h1000, 64'hFFF, 1, 1, 0, 64'hFFC, 4, 0, 0);
    send("R7",  3, 16'h10, 64'h1000, 64'hFFF, 1, 1, 0, 64'hFFD, 4, 0, 0);
    send("R3",  3, 16'h0,  64'h1000, 64'hFFF, 1, 1, 0, 64'h20, 1, 0, 0);
    send("R6",  9, 16'h0,  64'h1000, 64'hFFF, 0, 0, 0, 64'h20, 1, 1, 0);
    send("R4",  2, 16'h18, 64'h2000, 64'hFFFF, 1, 0, 0, 64'h40, 2, 1, 0);
    send("R6", 10, 16'h18, 64'h2000, 64'hFFFF, 1, 0, 0, 64'h40, 2, 1, 0);
    send("R5",  1, 16'h08, 64'h3000, 64'hFFFF, 0, 1, 0, 64'h80, 4, 0, 0);
    send("R5",  1, 16'h08, 64'h3000, 64'hFFFF, 0, 1, 0, 64'h80, 4, 0, 1);
    idle(2);
    send("R8",  2, 16'h18, 64'h4000, 64'hFF, 1, 1, 1, 64'h100, 4, 0, 0);
    send("R8",  2, 16'h18, 64'h4000, 64'hFF, 1, 1, 1, 64'hFF, 1, 0, 0);
    send("R8",  2, 16'h18, 64'h4000, 64'hFF, 1, 1, 1, 64'h0, 1, 1, 0);
    send("R6", 11, 16'h18, 64'h4000, 64'hFF, 0, 0, 1, 64'h10, 4, 0, 0);
    send("R6", 11, 16'h18, 64'h4000, 64'hFF, 0, 0, 1, 64'h100, 1, 0, 0);
    send("R7",  3, 16'h10, 64'h0, 64'hFFF, 1, 1, 0, 64'hFFF, 0, 0, 0);
    send("R7",  3, 16'h10, 64'h0, 64'hFFFFFFFF, 1, 1, 0, 64'hFFFFFFFE, 4, 0, 0);
    send("R2",  5, 16'h28, 64'hF0000000, 64'hFFFFFFFF, 1, 1, 0, 64'h20000000, 1, 0, 0);
    send("R9",  4, 16'h20, 64'h5000, 64'hFF, 1, 0, 0, 64'h100, 4, 1, 0);
    send("R9",  4, 16'h0,  64'h5000, 64'hFF, 1, 1, 0, 64'h200, 4, 0, 0);
    send("R9",  4, 16'h20, 64'h5000, 64'hFF, 1, 1, 0, 64'h10, 4, 1, 0);
    send("R9",  0, 16'h20, 64'h6000, 64'hFFF, 0, 0, 0, 64'h10, 2, 0, 0);
    send("R9",  0, 16'h20, 64'h6000, 64'hFFF, 0, 0, 0, 64'h10, 2, 0, 1);
    idle(4);

    checks++;
    if (q_fault.size() != 0) begin
      errors++;
      $display("FAIL R1: %0d responses missing, expected 0", q_fault.size());
    end
    finish_run();
  end

endmodule